// File: doc/BRIEF.md
# Convolution Weight Tile Fetcher with Flipped-Transpose Order

This block generates the command stream that fills the on-chip weight buffer of an output-stationary convolution engine with one kernel tile. Each command carries an external read address and the buffer slot that the returned word belongs in. Out-of-range channels produce a zero-fill command instead of a read. A single phase input makes the same engine usable for the inference pass and for the activation-gradient pass. In the gradient pass, the fetcher exchanges the roles of the layer's input and output channels and reads every kernel rotated by a half turn. Only one copy of the weights is therefore kept in external memory.

The weight array of a layer with `N_IN` input channels, `N_OUT` output channels and a `KSZ`×`KSZ` kernel sits at a base address in the order [out][in][row][col], row-major. A request names the first compute-output channel and the first compute-input channel of a `TILE_O`×`TILE_I` tile. In the gradient pass, compute outputs are the layer's input channels and compute inputs are its output channels. The engine asks for one tile per input-tile step and accumulates in place. The tile sizes, the kernel size and the layer sizes are all fixed when the design is built.

The controller has three states. `ST_IDLE` waits for `start`. `ST_ISSUE` presents one command per slot under a valid/ready handshake. `ST_FINISH` lasts one cycle and raises `done`. The transitions are: IDLE→ISSUE when `start` is seen; ISSUE→ISSUE while slots remain; ISSUE→FINISH when the last slot is accepted; FINISH→IDLE unconditionally.

Top module: `wf_fetch`

## Requirements
- R1: While reset is asserted and in the cycles after it until a start, `cmd_valid` and `done` are 0. A reset asserted mid-tile drops `cmd_valid` to 0 at the next clock edge.
- R2: A start in `ST_IDLE` latches `phase`, `base_addr`, `oc_base` and `ic_base`. The fetcher then issues exactly TILE_O·TILE_I·KSZ² commands. Their `cmd_buf_idx` runs 0,1,2,… with slot index ((to·TILE_I+ti)·KSZ+r)·KSZ+c. Kernels are issued with the tile-output offset `to` outermost, then `ti`, then row `r`, then column `c`.
- R3: With `phase`=0 (forward), slot (to,ti,r,c) reads base + ((co·N_IN+ci)·KSZ+r)·KSZ+c, where co=oc_base+to and ci=ic_base+ti.
- R4: With `phase`=1 (gradient), the channels are exchanged: compute input ci selects the layer output channel and compute output co selects the layer input channel. The read comes from kernel [ci][co].
- R5: With `phase`=1, slot row r and column c read kernel element (KSZ-1-r, KSZ-1-c).
- R6: A slot whose channels fall outside the layer issues `cmd_rd_en`=0 (zero-fill) but still takes its buffer slot. Forward requires co<N_OUT and ci<N_IN. Gradient requires co<N_IN and ci<N_OUT.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields stay unchanged.
- R8: `done` is 1 for exactly the one cycle after the last command is accepted, with `cmd_valid` 0. The block then returns to idle.
- R9: `start` and changes on the request inputs while a tile is in progress have no effect on the command stream.
- R10: Read addresses are offsets added to the latched `base_addr`, modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Tile request, sampled in idle |
| phase | input | 1 | 0 forward order, 1 flipped-transpose order |
| base_addr | input | ADDR_W | External address of the layer's weight array |
| oc_base | input | CH_W | First compute-output channel of the tile |
| ic_base | input | CH_W | First compute-input channel of the tile |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted when high with `cmd_valid` |
| cmd_rd_en | output | 1 | 1: read `cmd_rd_addr`; 0: write zero to the slot |
| cmd_rd_addr | output | ADDR_W | External read address |
| cmd_buf_idx | output | IDX_W | Weight buffer slot for this command |
| done | output | 1 | One-cycle tile-complete pulse |

## Verification
A wrong slot cursor appears at the ports on the very next accepted command. It shows up as a gap or repeat in `cmd_buf_idx`, together with a read address that belongs to another kernel element. A wrongly latched phase or base corrupts the first command of the tile, so the error is visible before any handshake completes. Range errors appear as `cmd_rd_en` set on a slot that should zero-fill, or cleared on a slot that should read. A terminal-state fault appears within one cycle of the last acceptance, as a missing, doubled or early `done`.

// File: rtl/wf_pkg.sv
package wf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FINISH
    } wf_state_e;

    typedef enum logic {
        PH_FWD = 1'b0,
        PH_BWD = 1'b1
    } wf_phase_e;
endpackage

// File: rtl/wf_cursor.sv
// Nested slot counter: column fastest, then row, then tile input, then tile output.
module wf_cursor #(
    parameter int TILE_O = 4,
    parameter int TILE_I = 4,
    parameter int KSZ    = 3,
    localparam int TO_W  = (TILE_O > 1) ? $clog2(TILE_O) : 1,
    localparam int TI_W  = (TILE_I > 1) ? $clog2(TILE_I) : 1,
    localparam int K_W   = (KSZ > 1) ? $clog2(KSZ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    output logic [TO_W-1:0] to_q,
    output logic [TI_W-1:0] ti_q,
    output logic [K_W-1:0]  r_q,
    output logic [K_W-1:0]  c_q,
    output logic            last
);
    logic c_end, r_end, ti_end, to_end;

    always_comb begin
        c_end  = (c_q == K_W'(KSZ - 1));
        r_end  = (r_q == K_W'(KSZ - 1));
        ti_end = (ti_q == TI_W'(TILE_I - 1));
        to_end = (to_q == TO_W'(TILE_O - 1));
        last   = c_end && r_end && ti_end && to_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            to_q <= '0;
            ti_q <= '0;
            r_q  <= '0;
            c_q  <= '0;
        end else if (step) begin
            if (!c_end) begin
                c_q <= c_q + K_W'(1);
            end else begin
                c_q <= '0;
                if (!r_end) begin
                    r_q <= r_q + K_W'(1);
                end else begin
                    r_q <= '0;
                    if (!ti_end) begin
                        ti_q <= ti_q + TI_W'(1);
                    end else begin
                        ti_q <= '0;
                        to_q <= to_end ? '0 : to_q + TO_W'(1);
                    end
                end
            end
        end
    end

    // Counters never leave their ranges (R2).
    p_cursor_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(c_q) < KSZ) && (int'(r_q) < KSZ) && (int'(ti_q) < TILE_I) && (int'(to_q) < TILE_O));
endmodule

// File: rtl/wf_addr_map.sv
// Maps a slot position to an external address, a buffer slot and a read/zero decision.
module wf_addr_map #(
    parameter int N_IN   = 6,
    parameter int N_OUT  = 5,
    parameter int KSZ    = 3,
    parameter int TILE_O = 4,
    parameter int TILE_I = 4,
    parameter int ADDR_W = 16,
    parameter int CH_W   = 8,
    localparam int TO_W  = (TILE_O > 1) ? $clog2(TILE_O) : 1,
    localparam int TI_W  = (TILE_I > 1) ? $clog2(TILE_I) : 1,
    localparam int K_W   = (KSZ > 1) ? $clog2(KSZ) : 1,
    localparam int TOTAL = TILE_O * TILE_I * KSZ * KSZ,
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic              phase,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CH_W-1:0]   oc_base,
    input  logic [CH_W-1:0]   ic_base,
    input  logic [TO_W-1:0]   to_q,
    input  logic [TI_W-1:0]   ti_q,
    input  logic [K_W-1:0]    r_q,
    input  logic [K_W-1:0]    c_q,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [IDX_W-1:0]  buf_idx
);
    import wf_pkg::*;

    int co, ci, lay_o, lay_i, er, ec, off, slot;

    always_comb begin
        co = int'(oc_base) + int'(to_q);
        ci = int'(ic_base) + int'(ti_q);
        if (wf_phase_e'(phase) == PH_BWD) begin
            lay_o = ci;
            lay_i = co;
            er    = KSZ - 1 - int'(r_q);
            ec    = KSZ - 1 - int'(c_q);
        end else begin
            lay_o = co;
            lay_i = ci;
            er    = int'(r_q);
            ec    = int'(c_q);
        end
        rd_en   = (lay_o < N_OUT) && (lay_i < N_IN);
        off     = ((lay_o * N_IN + lay_i) * KSZ + er) * KSZ + ec;
        rd_addr = base_addr + ADDR_W'(off);
        slot    = ((int'(to_q) * TILE_I + int'(ti_q)) * KSZ + int'(r_q)) * KSZ + int'(c_q);
        buf_idx = IDX_W'(slot);
    end
endmodule

// File: rtl/wf_fetch.sv
module wf_fetch #(
    parameter int N_IN   = 6,
    parameter int N_OUT  = 5,
    parameter int KSZ    = 3,
    parameter int TILE_O = 4,
    parameter int TILE_I = 4,
    parameter int ADDR_W = 16,
    parameter int CH_W   = 8,
    localparam int TO_W  = (TILE_O > 1) ? $clog2(TILE_O) : 1,
    localparam int TI_W  = (TILE_I > 1) ? $clog2(TILE_I) : 1,
    localparam int K_W   = (KSZ > 1) ? $clog2(KSZ) : 1,
    localparam int TOTAL = TILE_O * TILE_I * KSZ * KSZ,
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    localparam int LAYER_WORDS = N_IN * N_OUT * KSZ * KSZ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              phase,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CH_W-1:0]   oc_base,
    input  logic [CH_W-1:0]   ic_base,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_rd_en,
    output logic [ADDR_W-1:0] cmd_rd_addr,
    output logic [IDX_W-1:0]  cmd_buf_idx,
    output logic              done
);
    import wf_pkg::*;

    wf_state_e         state_q, state_d;
    logic              phase_q;
    logic [ADDR_W-1:0] base_q;
    logic [CH_W-1:0]   ocb_q, icb_q;
    logic              take, step, tile_last;
    logic [TO_W-1:0]   to_q;
    logic [TI_W-1:0]   ti_q;
    logic [K_W-1:0]    r_q, c_q;

    assign take = (state_q == ST_IDLE) && start;
    assign step = (state_q == ST_ISSUE) && cmd_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  if (cmd_ready && tile_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            base_q  <= '0;
            ocb_q   <= '0;
            icb_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                phase_q <= phase;
                base_q  <= base_addr;
                ocb_q   <= oc_base;
                icb_q   <= ic_base;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  cmd_valid = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    wf_cursor #(.TILE_O(TILE_O), .TILE_I(TILE_I), .KSZ(KSZ)) u_cursor (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take),
        .step  (step),
        .to_q  (to_q),
        .ti_q  (ti_q),
        .r_q   (r_q),
        .c_q   (c_q),
        .last  (tile_last)
    );

    wf_addr_map #(
        .N_IN(N_IN), .N_OUT(N_OUT), .KSZ(KSZ), .TILE_O(TILE_O), .TILE_I(TILE_I),
        .ADDR_W(ADDR_W), .CH_W(CH_W)
    ) u_map (
        .phase     (phase_q),
        .base_addr (base_q),
        .oc_base   (ocb_q),
        .ic_base   (icb_q),
        .to_q      (to_q),
        .ti_q      (ti_q),
        .r_q       (r_q),
        .c_q       (c_q),
        .rd_en     (cmd_rd_en),
        .rd_addr   (cmd_rd_addr),
        .buf_idx   (cmd_buf_idx)
    );

    // R2: every tile opens at slot 0 and slots advance by one per acceptance.
    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> (cmd_buf_idx == '0));
    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !tile_last) |=>
            (cmd_valid && (cmd_buf_idx == $past(cmd_buf_idx) + IDX_W'(1))));
    // R6: any read stays inside the layer's weight array.
    p_read_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_rd_en) |-> (int'(ADDR_W'(cmd_rd_addr - base_q)) < LAYER_WORDS));
    // R7: a stalled command is held.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_rd_addr) && $stable(cmd_buf_idx) && $stable(cmd_rd_en)));
    // R8: done follows the last acceptance, lasts one cycle and never overlaps a command.
    p_done_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cmd_valid && cmd_ready && tile_last) && !cmd_valid));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: the latched request cannot change while a tile is in progress.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) |=> ($stable(phase_q) && $stable(base_q) && $stable(ocb_q) && $stable(icb_q)));
endmodule

// File: tb/wf_fetch_test.sv
`timescale 1ns/100ps
module wf_fetch_test;
    localparam int N_IN = 6, N_OUT = 5, KSZ = 3, TILE_O = 4, TILE_I = 4;
    localparam int ADDR_W = 16, CH_W = 8;
    localparam int TOTAL = TILE_O * TILE_I * KSZ * KSZ;
    localparam int IDX_W = $clog2(TOTAL);
    localparam int NV = 6;
    // Vector table: phase, oc_base, ic_base, base address, ready pattern, poke start mid-tile
    localparam int V_PH  [NV] = '{0, 0, 1, 1, 1, 0};
    localparam int V_OC  [NV] = '{0, 4, 0, 4, 0, 8};
    localparam int V_IC  [NV] = '{0, 4, 0, 4, 4, 0};
    localparam int V_BASE[NV] = '{100, 0, 1000, 7, 65530, 300};
    localparam int V_MODE[NV] = '{0, 1, 2, 0, 1, 2};
    localparam int V_POKE[NV] = '{0, 0, 1, 0, 1, 0};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, phase = 1'b0, cmd_ready = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [CH_W-1:0]   oc_base = '0, ic_base = '0;
    logic cmd_valid, cmd_rd_en, done;
    logic [ADDR_W-1:0] cmd_rd_addr;
    logic [IDX_W-1:0]  cmd_buf_idx;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    wf_fetch #(.N_IN(N_IN), .N_OUT(N_OUT), .KSZ(KSZ), .TILE_O(TILE_O), .TILE_I(TILE_I),
               .ADDR_W(ADDR_W), .CH_W(CH_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .base_addr(base_addr),
        .oc_base(oc_base), .ic_base(ic_base), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rd_en(cmd_rd_en), .cmd_rd_addr(cmd_rd_addr), .cmd_buf_idx(cmd_buf_idx), .done(done));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected command for slot n, derived from R2..R6 and R10
    function automatic int model(input int ph, input int oc, input int ic, input int base,
                                 input int n, output bit en);
        int c, r, ti, to, co, ci, a;
        c  = n % KSZ;
        r  = (n / KSZ) % KSZ;
        ti = (n / (KSZ * KSZ)) % TILE_I;
        to = n / (KSZ * KSZ * TILE_I);
        co = oc + to;
        ci = ic + ti;
        if (ph == 0) begin
            en = (co < N_OUT) && (ci < N_IN);
            a  = ((co * N_IN + ci) * KSZ + r) * KSZ + c;
        end else begin
            en = (co < N_IN) && (ci < N_OUT);
            a  = ((ci * N_IN + co) * KSZ + (KSZ - 1 - r)) * KSZ + (KSZ - 1 - c);
        end
        return (base + a) % (1 << ADDR_W);
    endfunction

    task automatic run_tile(input int v);
        int n = 0, cyc = 0, s_addr = 0, s_idx = 0, s_en = 0, early = 0;
        bit stalled = 0, en;
        int ea;
        @(negedge clk);
        phase = V_PH[v][0]; oc_base = CH_W'(V_OC[v]); ic_base = CH_W'(V_IC[v]);
        base_addr = ADDR_W'(V_BASE[v]); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < TOTAL && cyc < 5000) begin
            case (V_MODE[v])
                1: cmd_ready = (cyc % 3) != 0;
                2: cmd_ready = (cyc % 2) == 1;
                default: cmd_ready = 1'b1;
            endcase
            // R9: a new request mid-tile must not disturb the stream
            if (V_POKE[v] != 0 && cyc == 6) begin
                start = 1'b1; phase = ~phase; oc_base = 8'd1; ic_base = 8'd2; base_addr = 16'd5;
            end else begin
                start = 1'b0;
            end
            if (done) early++;
            if (stalled) begin
                chk("R7 held addr", int'(cmd_rd_addr), s_addr);
                chk("R7 held idx", int'(cmd_buf_idx), s_idx);
                chk("R7 held rd_en", int'(cmd_rd_en), s_en);
                stalled = 0;
            end
            if (cmd_valid) begin
                if (cmd_ready) begin
                    ea = model(V_PH[v], V_OC[v], V_IC[v], V_BASE[v], n, en);
                    chk("R2 slot order", int'(cmd_buf_idx), n);
                    chk(V_PH[v] == 0 ? "R6 R3 rd_en fwd range" : "R6 R4 rd_en bwd range",
                        int'(cmd_rd_en), int'(en));
                    if (en) chk(V_PH[v] == 0 ? "R3 R10 fwd addr" : "R4 R5 R10 bwd addr",
                                int'(cmd_rd_addr), ea);
                    n++;
                end else begin
                    stalled = 1;
                    s_addr = int'(cmd_rd_addr); s_idx = int'(cmd_buf_idx); s_en = int'(cmd_rd_en);
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; cmd_ready = 1'b0;
        chk("R2 command count", n, TOTAL);
        chk("R8 no early done", early, 0);
        chk("R8 done after last", int'(done), 1);
        chk("R8 no command with done", int'(cmd_valid), 0);
        @(negedge clk);
        chk("R8 done single cycle", int'(done), 0);
        chk("R8 back to idle", int'(cmd_valid), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit en0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(cmd_valid), 0);
        chk("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle valid", int'(cmd_valid), 0);
        chk("R1 idle done", int'(done), 0);

        for (int v = 0; v < NV; v++) run_tile(v);

        // R5 directed: gradient order, first slot reads the far corner of kernel [0][0]
        @(negedge clk);
        phase = 1'b1; oc_base = '0; ic_base = '0; base_addr = 16'd40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R5 corner rotation", int'(cmd_rd_addr), 40 + KSZ * KSZ - 1);
        chk("R5 corner model", model(1, 0, 0, 40, 0, en0), 40 + KSZ * KSZ - 1);
        // R1 directed: reset in the middle of a tile
        cmd_ready = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0; cmd_ready = 1'b0;
        @(negedge clk);
        chk("R1 mid-tile reset valid", int'(cmd_valid), 0);
        chk("R1 mid-tile reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stays idle after reset", int'(cmd_valid), 0);
        // Recovery with a fresh tile
        run_tile(0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule